// File: doc/BRIEF.md
# Burst Address Sequencer with Linear/Interleaved Ordering

This block produces the word address for a synchronous burst memory. An external address is captured when either of two start strobes is seen at a rising clock edge. From that captured address the block then walks through a four-beat burst. Each step is one cycle in which the advance input is high. Only the two lowest address bits change during a burst, and the upper bits stay as they were loaded.

A static mode pin selects the order of the beats. In linear order the low bits count upward modulo four. In interleaved order the low bits are the loaded low bits XORed with the beat number. The processor-side strobe is gated by an active-low chip select; the controller-side strobe is never gated.

The address leaves the block as a plain registered output, qualified by `beat_valid`. There is no valid/ready handshake and no back-pressure. The consumer paces the burst itself through `advance`, and a beat stays on the output for as long as `advance` is low.

Top module: `bseq_burst_addr`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first load, `beat_valid` is 0 and `addr_out` is all zeros.
- R2: `start_ctrl` high at a clock edge loads `addr_in`. From the following cycle, `addr_out` equals the loaded address and `beat_valid` is 1. This holds in both order modes.
- R3: `start_proc` high at a clock edge while `cs_n` is low loads `addr_in` in the same way as R2.
- R4: `start_proc` is ignored while `cs_n` is high. It loads no address and does not restart the beat count, so `addr_out` is unchanged or keeps stepping as `advance` dictates.
- R5: During a burst, each edge with `advance` high and no load moves to the next beat. An edge with no load and `advance` low leaves `addr_out` unchanged.
- R6: With `order_sel` = 0 (linear), beat k has low bits (L + k) mod 4, where L is the loaded low pair.
- R7: With `order_sel` = 1 (interleaved), beat k has low bits L XOR k.
- R8: The upper address bits never change inside a burst. After beat 3, one more advance returns to beat 0 (the loaded address) and does not carry into bit 2.
- R9: A load has priority over `advance` at the same edge and restarts at beat 0. Both strobes high together (with `cs_n` low) cause one load of `addr_in`.
- R10: `advance` before the first load has no effect: `beat_valid` stays 0 and `addr_out` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External word address, captured on a load |
| start_proc | input | 1 | Processor-side burst start, gated by `cs_n` |
| start_ctrl | input | 1 | Controller-side burst start, ungated |
| cs_n | input | 1 | Active-low chip select; high blocks `start_proc` |
| advance | input | 1 | Step to the next beat at this edge |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order (static) |
| addr_out | output | ADDR_W | Address of the current beat |
| beat_valid | output | 1 | High once a burst has been loaded |

## Verification
Every result is registered once. A load or an advance presented before an edge is visible on `addr_out` and `beat_valid` in the cycle after that edge. The order mode acts combinationally on the stored beat count, so a change of mode shows at once. The bench drives each vector at a falling edge and checks it 1 ns after the next rising edge, so each check lands exactly one register stage after its stimulus. The vectors cover gated and ungated starts, wrap in both orders, and a load that collides with an advance.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Low-bit address for beat number k from loaded low bits l
  function automatic logic [1:0] beat_low(input logic [1:0] l, input logic [1:0] k,
                                          input order_e ord);
    if (ord == ORD_INTERLEAVE) beat_low = l ^ k;
    else                       beat_low = l + k;
  endfunction
endpackage

// File: rtl/bseq_load_ctrl.sv
module bseq_load_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_proc,
  input  logic              start_ctrl,
  input  logic              cs_n,
  output logic              load,
  output logic [ADDR_W-1:0] base_q
);
  logic proc_ok;

  // processor strobe counts only while selected; it wins ties, both load the same word
  assign proc_ok = start_proc & ~cs_n;
  assign load    = proc_ok | start_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= addr_in;
  end
endmodule

// File: rtl/bseq_beat_counter.sv
module bseq_beat_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  output logic [CNT_W-1:0] beat_q,
  output logic             active_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      beat_q   <= '0;
      active_q <= 1'b1;
    end else if (advance && active_q) begin
      beat_q   <= beat_q + 1'b1;   // natural wrap after the last beat
    end
  end
endmodule

// File: rtl/bseq_addr_map.sv
module bseq_addr_map
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  beat,
  input  order_e            ord,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - CNT_W;

  generate
    if (CNT_W == 2) begin : g_fixed
      assign addr[1:0] = beat_low(base[1:0], beat, ord);
    end else begin : g_generic
      assign addr[CNT_W-1:0] = (ord == ORD_INTERLEAVE) ? (base[CNT_W-1:0] ^ beat)
                                                       : (base[CNT_W-1:0] + beat);
    end
    if (HI_W > 0) begin : g_hi
      assign addr[ADDR_W-1:CNT_W] = base[ADDR_W-1:CNT_W];
    end
  endgenerate
endmodule

// File: rtl/bseq_burst_addr.sv
module bseq_burst_addr
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_proc,
  input  logic              start_ctrl,
  input  logic              cs_n,
  input  logic              advance,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic              beat_valid
);
  localparam int CNT_W = 2;

  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q;
  logic              active_q;
  order_e            ord;

  assign ord = order_e'(order_sel);

  bseq_load_ctrl #(.ADDR_W(ADDR_W)) u_load (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .start_proc(start_proc),
    .start_ctrl(start_ctrl), .cs_n(cs_n), .load(load), .base_q(base_q)
  );

  bseq_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .beat_q(beat_q), .active_q(active_q)
  );

  bseq_addr_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_map (
    .base(base_q), .beat(beat_q), .ord(ord), .addr(addr_out)
  );

  assign beat_valid = active_q;

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ctrl |=> (addr_out == $past(addr_in)) && beat_valid);

  // R4
  blocked_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_proc && cs_n && !start_ctrl && !advance) |=> $stable(addr_out));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ctrl && !(start_proc && !cs_n) && !advance && $stable(order_sel))
      |=> $stable(addr_out));

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ctrl && !(start_proc && !cs_n))
      |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]));

  // R10
  no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid && !start_ctrl && !(start_proc && !cs_n)) |=> !beat_valid);
endmodule

// File: tb/bseq_burst_addr_test.sv
`timescale 1ns/1ps
module bseq_burst_addr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr_in = '0;
  logic        start_proc = 0, start_ctrl = 0, cs_n = 1, advance = 0, order_sel = 0;
  logic [15:0] addr_out;
  logic        beat_valid;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bseq_burst_addr #(.ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .start_proc(start_proc),
    .start_ctrl(start_ctrl), .cs_n(cs_n), .advance(advance), .order_sel(order_sel),
    .addr_out(addr_out), .beat_valid(beat_valid)
  );

  // {proc,ctrl,cs_n,adv,mode} addr_in expected_addr expected_valid
  localparam logic [37:0] VEC [17] = '{
    {5'b01100, 16'h1236, 16'h1236, 1'b1},  // R2 ctrl load
    {5'b00110, 16'h0000, 16'h1237, 1'b1},  // R6
    {5'b00110, 16'h0000, 16'h1234, 1'b1},  // R6 low wraps, R8 no carry
    {5'b00110, 16'h0000, 16'h1235, 1'b1},  // R6
    {5'b00110, 16'h0000, 16'h1236, 1'b1},  // R8 back to beat 0
    {5'b00100, 16'h0000, 16'h1236, 1'b1},  // R5 hold
    {5'b10100, 16'hABCD, 16'h1236, 1'b1},  // R4 blocked
    {5'b10000, 16'hABCD, 16'hABCD, 1'b1},  // R3 proc load
    {5'b01101, 16'h00F2, 16'h00F2, 1'b1},  // R2 interleaved load
    {5'b00111, 16'h0000, 16'h00F3, 1'b1},  // R7
    {5'b00111, 16'h0000, 16'h00F0, 1'b1},  // R7
    {5'b00111, 16'h0000, 16'h00F1, 1'b1},  // R7
    {5'b00111, 16'h0000, 16'h00F2, 1'b1},  // R8 interleaved wrap
    {5'b11011, 16'h5551, 16'h5551, 1'b1},  // R9 both strobes + advance
    {5'b00111, 16'h0000, 16'h5550, 1'b1},  // R7
    {5'b11101, 16'h7773, 16'h7773, 1'b1},  // R4 ctrl loads despite gate
    {5'b10111, 16'h0000, 16'h7772, 1'b1}   // R4 blocked strobe keeps stepping
  };

  task automatic check(input string req, input logic [15:0] ea, input logic ev);
    n_run++;
    if (addr_out !== ea || beat_valid !== ev) begin
      n_fail++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
               req, addr_out, beat_valid, ea, ev);
    end
  endtask

  initial begin
    #200000;
    n_fail++; n_run++;
    $display("FAIL watchdog: run hung");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 16'h0000, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", 16'h0000, 1'b0);
    @(negedge clk); advance = 1'b1;
    @(posedge clk); #1;
    check("R10 advance before load", 16'h0000, 1'b0);

    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      {start_proc, start_ctrl, cs_n, advance, order_sel} = VEC[i][37:33];
      addr_in = VEC[i][32:17];
      @(posedge clk); #1;
      check($sformatf("vector %0d", i), VEC[i][16:1], VEC[i][0]);
    end

    // R9 load collides with advance mid-burst, linear mode
    @(negedge clk);
    {start_proc, start_ctrl, cs_n, advance, order_sel} = 5'b01010;
    addr_in = 16'h4442;
    @(posedge clk); #1;
    check("R9 load beats advance", 16'h4442, 1'b1);
    @(negedge clk); start_ctrl = 0;
    @(posedge clk); #1;
    check("R6 step after collision", 16'h4443, 1'b1);

    // R1 reset mid-burst
    @(negedge clk); advance = 0; rst_n = 1'b0;
    #1;
    check("R1 reset mid-burst", 16'h0000, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule